// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block models a single-port synchronous SRAM that accepts one external address at the start of a burst and then produces the remaining addresses of a four-beat burst itself. Only the two lowest address bits move. The upper bits stay where the strobed address put them. The low bits step either upward modulo four or as the start value XOR the beat index. A static mode input chooses the order at run time.

A second static input selects the read latency. With flow-through, data appears after the access edge. With pipelined reads, data appears one edge later, after an extra output register. A sleep input puts the core in standby. While it is high, accesses are ignored, the array keeps its contents, and the outputs are held at zero. Writes go to the same generated burst addresses as reads.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `rd_data` is all zeros and `rd_valid` is low.
- R2: A cycle with `adr_strobe` high (and `sleep` low) accesses `adr` directly. Later advanced beats keep address bits above bit 1 equal to that strobed address.
- R3: With `order_sel` = 0 (linear), beat k of a burst accesses low bits (start + k) mod 4, where start is `adr[1:0]` at the strobe.
- R4: With `order_sel` = 1 (interleaved), beat k accesses low bits start XOR k.
- R5: A fifth consecutive beat (the fourth `advance` after the strobe) returns to the start address in both orders.
- R6: When `adr_strobe` and `advance` are high in the same cycle, the strobe wins. The access uses `adr` and a new burst starts.
- R7: With `out_sel` = 0 (flow-through), data for a read accessed at clock edge n is on `rd_data` with `rd_valid` high right after edge n.
- R8: With `out_sel` = 1 (pipelined), the same data and `rd_valid` appear right after edge n+1, one edge later than in R7.
- R9: An access with `wr_en` high writes `wr_data` to the generated burst address and produces no read (`rd_valid` stays low for it).
- R10: While `sleep` is high, strobes, advances and writes are ignored, stored words are kept, `rd_data` is zero and `rd_valid` is low.
- R11: An edge with neither `adr_strobe` nor `advance` high performs no access, so the matching output slot has `rd_valid` low and `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adr_strobe | input | 1 | Load `adr` and start a burst |
| advance | input | 1 | Step the burst one beat |
| wr_en | input | 1 | Access is a write when high |
| adr | input | AW | External word address |
| wr_data | input | DW | Write data |
| order_sel | input | 1 | 0 linear, 1 interleaved burst order |
| out_sel | input | 1 | 0 flow-through, 1 pipelined read |
| sleep | input | 1 | Standby when high |
| rd_data | output | DW | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid |

## Verification
The bench builds the core with its defaults: AW = 5, which gives a 32-word array, and DW = 36. At this size the whole array is filled with address-derived words. Bursts from every start value in three address blocks are then read in both orders and both latency modes, each running into the fifth wrap beat, so every sequence entry can be compared against arithmetic done in the bench. The small array also lets sleep, write-burst placement and strobe priority be checked on known words.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW = 5,
  parameter int DW = 36,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adr_strobe,
  input  logic          advance,
  input  logic          wr_en,
  input  logic [AW-1:0] adr,
  input  logic [DW-1:0] wr_data,
  input  logic          order_sel,
  input  logic          out_sel,
  input  logic          sleep,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-3:0] hi_q;
  logic [1:0]    start_q, beat_q;
  logic [DW-1:0] stage1_q, stage2_q;
  logic          v1_q, v2_q;

  wire           awake    = !sleep;
  wire           go       = awake && (adr_strobe || advance);
  wire [1:0]     seq_lo   = order_sel ? (start_q ^ beat_q) : (start_q + beat_q);
  wire [AW-1:0]  acc_addr = adr_strobe ? adr : {hi_q, seq_lo};
  wire           rd_go    = go && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      start_q  <= '0;
      beat_q   <= '0;
      stage1_q <= '0;
      stage2_q <= '0;
      v1_q     <= 1'b0;
      v2_q     <= 1'b0;
    end else if (awake) begin
      if (adr_strobe) begin
        hi_q    <= adr[AW-1:2];
        start_q <= adr[1:0];
        beat_q  <= 2'd1;
      end else if (advance) begin
        beat_q  <= beat_q + 2'd1;
      end
      v1_q <= rd_go;
      if (rd_go) stage1_q <= mem[acc_addr];
      v2_q     <= v1_q;
      stage2_q <= stage1_q;
    end else begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (go && wr_en) mem[acc_addr] <= wr_data;
  end

  assign rd_valid = awake && (out_sel ? v2_q : v1_q);
  assign rd_data  = rd_valid ? (out_sel ? stage2_q : stage1_q) : '0;

endmodule

module sync_burst_sram_chk #(
  parameter int AW = 5,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adr_strobe,
  input logic          advance,
  input logic          wr_en,
  input logic [AW-1:0] adr,
  input logic          order_sel,
  input logic          out_sel,
  input logic          sleep,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic [AW-1:0] acc_addr
);

  // R10
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rd_valid && rd_data == '0));

  // R7
  flow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !out_sel && !sleep && !$past(sleep))
      |-> rd_valid == $past((adr_strobe || advance) && !wr_en));

  // R8
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && out_sel && !sleep && !$past(sleep) && !$past(sleep, 2))
      |-> rd_valid == $past((adr_strobe || advance) && !wr_en, 2));

  // R3 R4
  second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(adr_strobe && !sleep) && !adr_strobe && advance && !sleep)
      |-> acc_addr == {$past(adr[AW-1:2]),
                       (order_sel ? ($past(adr[1:0]) ^ 2'd1) : ($past(adr[1:0]) + 2'd1))});

  // R2
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past((adr_strobe || advance) && !sleep) && !adr_strobe && advance && !sleep)
      |-> acc_addr[AW-1:2] == $past(acc_addr[AW-1:2]));

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adr_strobe(adr_strobe), .advance(advance),
  .wr_en(wr_en), .adr(adr), .order_sel(order_sel), .out_sel(out_sel),
  .sleep(sleep), .rd_data(rd_data), .rd_valid(rd_valid), .acc_addr(acc_addr)
);

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  localparam int AW = 5;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adr_strobe = 1'b0, advance = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] wr_data = '0;
  logic order_sel = 1'b1, out_sel = 1'b1, sleep = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_burst_sram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .adr_strobe(adr_strobe), .advance(advance),
    .wr_en(wr_en), .adr(adr), .wr_data(wr_data), .order_sel(order_sel),
    .out_sel(out_sel), .sleep(sleep), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return (DW'(a) * 36'h1_0203_0405) ^ 36'h5_A5A5_A5A5;
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input bit ord, input int k);
    logic [1:0] lo;
    lo = ord ? (s[1:0] ^ 2'(k)) : (s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    adr_strobe = 1'b0; advance = 1'b0; wr_en = 1'b0;
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    adr_strobe = 1'b1; advance = 1'b0; wr_en = 1'b1; adr = AW'(a); wr_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic read_burst(input logic [AW-1:0] s, input bit ord, input bit pm);
    order_sel = ord; out_sel = pm;
    for (int i = 0; i <= 5; i++) begin
      string req;
      int k;
      @(negedge clk);
      wr_en = 1'b0;
      if (i == 0) begin adr_strobe = 1'b1; advance = 1'b0; adr = s; end
      else if (i < 5) begin adr_strobe = 1'b0; advance = 1'b1; end
      else idle();
      @(posedge clk);
      #1;
      k = pm ? i - 1 : i;
      req = pm ? "R8" : "R7";
      if (k >= 0 && k < 5) begin
        logic [DW-1:0] e;
        e = pat(int'(beat_addr(s, ord, k)));
        req = (k == 4) ? {req, "/R5"} : (ord ? {req, "/R4"} : {req, "/R3"});
        check(rd_valid === 1'b1 && rd_data === e, req, rd_data, e);
      end else begin
        check(rd_valid === 1'b0 && rd_data === '0, k < 0 ? "R8 latency" : "R11", rd_data, '0);
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic read_one(input int a, input logic [DW-1:0] e, input string req);
    order_sel = 1'b0; out_sel = 1'b0;
    @(negedge clk);
    adr_strobe = 1'b1; advance = 1'b0; wr_en = 1'b0; adr = AW'(a);
    @(posedge clk);
    #1;
    check(rd_valid === 1'b1 && rd_data === e, req, rd_data, e);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(rd_valid === 1'b0 && rd_data === '0, "R1", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(rd_valid === 1'b0 && rd_data === '0, "R1", rd_data, '0);

    for (int a = 0; a < (1 << AW); a++) write_word(a, pat(a));

    for (int ord = 0; ord < 2; ord++)
      for (int pm = 0; pm < 2; pm++)
        for (int h = 0; h < 8; h += 3)
          for (int s = 0; s < 4; s++)
            read_burst(AW'(h * 4 + s), ord[0], pm[0]);

    // R6: strobe overrides a concurrent advance
    order_sel = 1'b0; out_sel = 1'b0;
    @(negedge clk); adr_strobe = 1'b1; advance = 1'b0; adr = AW'(9);
    @(posedge clk); #1; check(rd_data === pat(9), "R6 start", rd_data, pat(9));
    @(negedge clk); adr_strobe = 1'b0; advance = 1'b1;
    @(posedge clk); #1; check(rd_data === pat(10), "R6 step", rd_data, pat(10));
    @(negedge clk); adr_strobe = 1'b1; advance = 1'b1; adr = AW'(20);
    @(posedge clk); #1; check(rd_valid === 1'b1 && rd_data === pat(20), "R6", rd_data, pat(20));
    @(negedge clk); adr_strobe = 1'b0; advance = 1'b1;
    @(posedge clk); #1; check(rd_data === pat(21), "R6 next", rd_data, pat(21));
    @(negedge clk); idle();

    // R9: interleaved write burst from 22 lands on 22, 23, 20, 21
    order_sel = 1'b1; out_sel = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = ~pat(100 + k);
      if (k == 0) begin adr_strobe = 1'b1; advance = 1'b0; adr = AW'(22); end
      else begin adr_strobe = 1'b0; advance = 1'b1; end
      @(posedge clk); #1;
      check(rd_valid === 1'b0, "R9 no read", DW'(rd_valid), '0);
    end
    @(negedge clk); idle();
    for (int k = 0; k < 4; k++)
      read_one(int'(beat_addr(AW'(22), 1'b1, k)), ~pat(100 + k), "R9");

    // R10: standby ignores accesses and keeps contents
    for (int pm = 0; pm < 2; pm++) begin
      out_sel = pm[0];
      @(negedge clk); sleep = 1'b1; adr_strobe = 1'b1; wr_en = 1'b0; adr = AW'(3);
      @(posedge clk); #1; check(rd_valid === 1'b0 && rd_data === '0, "R10 read", rd_data, '0);
      @(negedge clk); wr_en = 1'b1; adr = AW'(3); wr_data = '1;
      @(posedge clk); #1; check(rd_valid === 1'b0 && rd_data === '0, "R10 write", rd_data, '0);
      @(negedge clk); idle(); sleep = 1'b0;
      @(posedge clk); #1; check(rd_valid === 1'b0 && rd_data === '0, "R10 wake", rd_data, '0);
      @(negedge clk);
      read_one(3, pat(3), "R10 kept");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule